// File: doc/BRIEF.md
# Channel Receive Word Unpacker

This block terminates the receiving end of a one-way data channel. The transmitter offers 64-bit beats with a write strobe and a two-bit word-valid code. The receiver answers with a single ready signal. Each accepted beat is held in a one-beat buffer. Its meaningful 32-bit words then leave one at a time, lowest first, on a valid/ready stream towards local logic.

Channel ready is high only while the buffer is empty, or while the last word of the held beat is being taken in the current cycle. The transmitter must wait for ready before writing, and the receiver therefore never has to drop a legal beat. When the consumer takes a word every cycle and every beat carries one word, a new beat can be accepted on every clock.

Two kinds of protocol fault set a sticky error flag that only reset clears: a beat whose word-valid code is undefined, and a write strobe that arrives while ready is low. Neither kind of beat is stored.

On the output stream, a word is transferred on a rising edge where both out_valid and out_ready are high. While out_valid is high and out_ready is low, the presented word holds still. out_valid never waits for out_ready.

Top module: `chan_rx_unpacker`

## Requirements
- R1: After reset, ch_rdy is 1, out_valid is 0 and proto_err is 0.
- R2: A beat written with code 2'b11 produces two words in order: first ch_data[31:0], then ch_data[63:32]. Code bit 0 marks the low word and code bit 1 marks the high word.
- R3: A beat written with code 2'b01 produces exactly one word, ch_data[31:0]. ch_data[63:32] is never presented.
- R4: While a beat is held, ch_rdy is 0 unless the last word of that beat is accepted in the same cycle. With the buffer empty, ch_rdy is 1.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_word stays unchanged on the following cycle.
- R6: A write with code 2'b00 or 2'b10 while ch_rdy is 1 is discarded, so no word is presented, and proto_err becomes 1.
- R7: A write while ch_rdy is 0 is discarded, the held beat's words come out unchanged, and proto_err becomes 1.
- R8: If out_ready is held at 1 and a 2'b01 beat is written every cycle, one word is presented per cycle, each one clock after its write, and ch_rdy stays 1.
- R9: Once proto_err is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_wr | input | 1 | Channel write strobe |
| ch_data | input | 64 | Channel beat, two 32-bit words |
| ch_code | input | 2 | Word-valid code (bit i marks word i) |
| ch_rdy | output | 1 | Ready back to transmitter |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts word |
| out_word | output | 32 | Output word |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The assertions assume that out_ready, ch_wr and ch_code are stable between clock edges. They also assume that reset is held for at least one clock before the first check counts. The bench meets both by changing inputs only on falling edges. The protocol-fault assertions expect bad writes, and the stimulus sends them on purpose to confirm that proto_err sets. The assertions never assume a well-behaved transmitter.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  parameter int DEF_WORD_W = 32;
  parameter int DEF_NWORDS = 2;

  // A code is legal when its set bits form a non-empty run starting at bit 0.
  function automatic bit code_is_legal(input logic [DEF_NWORDS-1:0] code);
    logic [DEF_NWORDS-1:0] nxt;
    nxt = code + 1'b1;
    return (code != '0) && ((code & nxt) == '0);
  endfunction
endpackage

// File: rtl/rxu_code_check.sv
module rxu_code_check #(
  parameter int NWORDS = 2,
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic [NWORDS-1:0] code,
  output logic              legal,
  output logic [IDX_W-1:0]  last_idx
);
  logic [NWORDS-1:0] bumped;

  always_comb begin
    bumped   = code + 1'b1;
    legal    = (code != '0) && ((code & bumped) == '0);
    last_idx = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (code[i]) last_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/rxu_beat_buf.sv
module rxu_beat_buf #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 2,
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int BEAT_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BEAT_W-1:0] load_data,
  input  logic [IDX_W-1:0]  load_last,
  input  logic              take,
  output logic              full,
  output logic              at_last,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [BEAT_W-1:0] beat
);
  logic [IDX_W-1:0] last_q;

  assign at_last = (cur_idx == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      cur_idx <= '0;
      last_q  <= '0;
      beat    <= '0;
    end else if (load) begin
      full    <= 1'b1;
      cur_idx <= '0;
      last_q  <= load_last;
      beat    <= load_data;
    end else if (take && full) begin
      if (at_last) full <= 1'b0;
      else         cur_idx <= cur_idx + 1'b1;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(take && at_last)) |-> !load);

  // R2
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && take && !at_last && !load) |=> (full && cur_idx == $past(cur_idx) + 1'b1));
endmodule

// File: rtl/rxu_word_mux.sv
module rxu_word_mux #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 2,
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int BEAT_W = WORD_W * NWORDS
) (
  input  logic [BEAT_W-1:0] beat,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] lanes [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_lane
    assign lanes[g] = beat[g*WORD_W +: WORD_W];
  end

  assign word = lanes[idx];
endmodule

// File: rtl/rxu_err_flag.sv
module rxu_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic rdy,
  input  logic legal,
  output logic err
);
  always_ff @(posedge clk) begin
    if (!rst_n)                     err <= 1'b0;
    else if (wr && (!rdy || !legal)) err <= 1'b1;
  end

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/chan_rx_unpacker.sv
module chan_rx_unpacker
  import rxu_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int NWORDS = DEF_NWORDS,
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int BEAT_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_wr,
  input  logic [BEAT_W-1:0] ch_data,
  input  logic [NWORDS-1:0] ch_code,
  output logic              ch_rdy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              proto_err
);
  logic             legal, full, at_last, load, take, drain;
  logic [IDX_W-1:0] last_idx, cur_idx;
  logic [BEAT_W-1:0] beat;

  rxu_code_check #(.NWORDS(NWORDS)) u_code (
    .code(ch_code), .legal(legal), .last_idx(last_idx)
  );

  assign take      = full && out_ready;
  assign drain     = take && at_last;
  assign ch_rdy    = !full || drain;
  assign load      = ch_wr && ch_rdy && legal;
  assign out_valid = full;

  rxu_beat_buf #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(ch_data),
    .load_last(last_idx), .take(take), .full(full), .at_last(at_last),
    .cur_idx(cur_idx), .beat(beat)
  );

  rxu_word_mux #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_mux (
    .beat(beat), .idx(cur_idx), .word(out_word)
  );

  rxu_err_flag u_err (
    .clk(clk), .rst_n(rst_n), .wr(ch_wr), .rdy(ch_rdy), .legal(legal),
    .err(proto_err)
  );

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R4
  rdy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !ch_rdy);

  // R6
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr && ch_rdy && !legal) |=> (!out_valid && proto_err));

  // R7
  wr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr && !ch_rdy) |=> proto_err);
endmodule

// File: tb/chan_rx_unpacker_bench.sv
module chan_rx_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_wr = 1'b0;
  logic [63:0] ch_data = '0;
  logic [1:0]  ch_code = '0;
  logic        ch_rdy, out_valid, proto_err;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  chan_rx_unpacker u_chan_rx_unpacker (
    .clk(clk), .rst_n(rst_n), .ch_wr(ch_wr), .ch_data(ch_data),
    .ch_code(ch_code), .ch_rdy(ch_rdy), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .proto_err(proto_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ch_wr = 1'b0; out_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(ch_rdy == 1'b1, "R1 rdy", ch_rdy, 1);
    check(out_valid == 1'b0, "R1 valid", out_valid, 0);
    check(proto_err == 1'b0, "R1 err", proto_err, 0);
  endtask

  task automatic t_two_word();
    @(negedge clk);
    ch_wr = 1'b1; ch_data = 64'hAAAA0002_BBBB0001; ch_code = 2'b11; out_ready = 1'b0;
    #1 check(ch_rdy, "R4 empty rdy", ch_rdy, 1);
    @(negedge clk);
    ch_wr = 1'b0;
    #1;
    check(out_valid && out_word == 32'hBBBB0001, "R2 low first", out_word, 32'hBBBB0001);
    check(!ch_rdy, "R4 held no rdy", ch_rdy, 0);
    @(negedge clk);
    #1 check(out_valid && out_word == 32'hBBBB0001, "R5 hold", out_word, 32'hBBBB0001);
    out_ready = 1'b1;
    #1 check(!ch_rdy, "R4 non-last take", ch_rdy, 0);
    @(negedge clk);
    #1;
    check(out_valid && out_word == 32'hAAAA0002, "R2 high second", out_word, 32'hAAAA0002);
    check(ch_rdy, "R4 last take rdy", ch_rdy, 1);
    @(negedge clk);
    #1 check(!out_valid, "R2 done", out_valid, 0);
    out_ready = 1'b0;
  endtask

  task automatic t_one_word();
    @(negedge clk);
    ch_wr = 1'b1; ch_data = 64'hDEAD0000_00001111; ch_code = 2'b01; out_ready = 1'b1;
    @(negedge clk);
    ch_wr = 1'b0;
    #1 check(out_valid && out_word == 32'h00001111, "R3 low word", out_word, 32'h00001111);
    @(negedge clk);
    #1 check(!out_valid, "R3 no high word", out_valid, 0);
    out_ready = 1'b0;
  endtask

  task automatic t_full_rate();
    out_ready = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k > 0) begin
        #1;
        check(out_valid && out_word == 32'(100 + k - 1), "R8 word per cycle", out_word, 100 + k - 1);
        check(ch_rdy, "R8 rdy stays", ch_rdy, 1);
      end
      ch_wr = 1'b1; ch_code = 2'b01; ch_data = {32'hFFFF_FFFF, 32'(100 + k)};
    end
    @(negedge clk);
    ch_wr = 1'b0;
    #1 check(out_valid && out_word == 32'd104, "R8 last", out_word, 104);
    @(negedge clk);
    #1 check(!out_valid, "R8 drained", out_valid, 0);
    out_ready = 1'b0;
  endtask

  task automatic t_bad_code(input logic [1:0] c);
    do_reset();
    @(negedge clk);
    ch_wr = 1'b1; ch_code = c; ch_data = 64'h12345678_9ABCDEF0;
    @(negedge clk);
    ch_wr = 1'b0;
    #1;
    check(!out_valid, "R6 discarded", out_valid, 0);
    check(proto_err, "R6 err set", proto_err, 1);
    @(negedge clk); @(negedge clk);
    #1 check(proto_err && !out_valid, "R9 sticky", proto_err, 1);
  endtask

  task automatic t_wr_blocked();
    do_reset();
    @(negedge clk);
    ch_wr = 1'b1; ch_code = 2'b11; ch_data = 64'h00000022_00000011; out_ready = 1'b0;
    @(negedge clk);
    ch_data = 64'h00000044_00000033; ch_code = 2'b01;
    @(negedge clk);
    ch_wr = 1'b0;
    #1;
    check(proto_err, "R7 err set", proto_err, 1);
    check(out_valid && out_word == 32'h11, "R7 held low", out_word, 32'h11);
    out_ready = 1'b1;
    @(negedge clk);
    #1 check(out_valid && out_word == 32'h22, "R7 held high", out_word, 32'h22);
    @(negedge clk);
    #1 check(!out_valid, "R7 no extra", out_valid, 0);
    out_ready = 1'b0;
    do_reset();
    #1 check(!proto_err, "R9 reset clears", proto_err, 0);
  endtask

  initial begin
    t_reset();
    t_two_word();
    t_one_word();
    t_full_rate();
    t_bad_code(2'b00);
    t_bad_code(2'b10);
    t_wr_blocked();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule